// File: doc/BRIEF.md
# Interrupt flag and enable controller

This block holds the interrupt bookkeeping of a small 8-bit microcontroller core. Three event sources feed it. The first is an external pin whose active edge can be selected. The second is a one-cycle pulse raised when the 8-bit timer wraps. The third is any change on the upper nibble of an 8-bit input port. Each source sets a sticky flag in one shared 8-bit control register. That register also holds one enable bit per source and a global enable. The core reads the register directly and writes it over a simple strobe-and-data bus.

The block drives three outputs:
- `irq_req`: a request qualified by the global enable.
- `vec_req`: a branch-to-vector request. It is raised only while the core is awake.
- `wake_req`: a wake-up request while the core sleeps. It ignores the global enable.

When the core takes an interrupt, its `int_ack` strobe clears the global enable. A return strobe sets the global enable again. Saving the working registers is left to software.

The pin and port inputs pass through a two-flop synchronizer. Port change is judged against a reference copy of the nibble. That copy is reloaded each time the core reads the port.

Top module: `irq_flag_ctl`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00 and `irq_req`, `vec_req` and `wake_req` are 0.
- R2: With `edge_rise`=1, a 0-to-1 transition on `ext_pin` sets flag bit 1. A 1-to-0 transition leaves bit 1 unchanged.
- R3: With `edge_rise`=0, a 1-to-0 transition on `ext_pin` sets bit 1. A 0-to-1 transition leaves it unchanged.
- R4: A cycle with `tmr_wrap`=1 sets flag bit 2 at the next clock edge.
- R5: While the synchronized `port_hi` differs from the reference nibble, flag bit 0 is set on every cycle. A `port_rd` strobe loads the reference from the synchronized nibble. The reference resets to 0.
- R6: Register bits are: 0 port-change flag, 1 pin flag, 2 timer flag, 3 port-change enable, 4 pin enable, 5 timer enable, 6 reserved (always reads 0), 7 global enable. A write loads all bits except bit 6. Without a write, a set flag stays set.
- R7: If a hardware set and a write of 0 hit the same flag in the same cycle, the flag ends up set.
- R8: Let `any` be the OR, over the three sources, of flag AND enable (each flag bit n with enable bit n+3). `irq_req` equals global enable AND `any`, registered one cycle. A flag whose enable is 0 never raises `irq_req`.
- R9: `wake_req` equals `sleeping` AND `any`, registered one cycle, whatever the global enable.
- R10: `vec_req` equals `irq_req`'s condition AND NOT `sleeping`, registered one cycle.
- R11: `int_ack` clears bit 7. A `reti` strobe sets bit 7 unless `int_ack` or a write occurs in the same cycle. `int_ack` has priority over a write.
- R12: A level on `ext_pin` or `port_hi` is first sampled at one clock edge. The resulting flag is set at the second edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| edge_rise | input | 1 | 1 selects the rising edge, 0 the falling edge |
| tmr_wrap | input | 1 | One-cycle timer wrap pulse |
| port_hi | input | 4 | Upper nibble of the input port (asynchronous) |
| port_rd | input | 1 | Port read strobe; reloads the change reference |
| reg_wr | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control register contents |
| int_ack | input | 1 | Interrupt taken; clears the global enable |
| reti | input | 1 | Return from interrupt; sets the global enable |
| sleeping | input | 1 | Core is in sleep |
| irq_req | output | 1 | Interrupt request |
| vec_req | output | 1 | Branch-to-vector request |
| wake_req | output | 1 | Wake-up request |

## Verification
The hardest case to reach is a software clear landing on the same edge as a hardware set. The stimulus drives a write of 0 on the very cycle that the timer pulse is asserted. It also clears the port-change flag while the port nibble still differs from its reference, which keeps setting the flag. A further sequence places a flagged, enabled source under a cleared global enable, first with the core awake and then asleep. This separates the wake path from the vector path.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W    = 8;
  localparam int NIB_W    = 4;
  localparam int B_PC_F   = 0;
  localparam int B_PIN_F  = 1;
  localparam int B_TMR_F  = 2;
  localparam int B_PC_E   = 3;
  localparam int B_PIN_E  = 4;
  localparam int B_TMR_E  = 5;
  localparam int B_RSVD   = 6;
  localparam int B_GIE    = 7;
  localparam int N_SRC    = 3;
  localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << B_RSVD);
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic pin_s;
  logic pin_prev;

  irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin),
    .q   (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= 1'b0;
    else     pin_prev <= pin_s;
  end

  // active edge: level moved and now equals the selected polarity
  assign hit = (pin_s ^ pin_prev) & ~(pin_s ^ rise_sel);
endmodule

// File: rtl/nib_change_det.sv
module nib_change_det #(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic         snap,
  output logic         diff
);
  logic [W-1:0] pins_s;
  logic [W-1:0] ref_q;

  irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst)       ref_q <= '0;
    else if (snap) ref_q <= pins_s;
  end

  assign diff = |(pins_s ^ ref_q);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] hw_set,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ack,
  input  logic             ret,
  output logic [REG_W-1:0] ctl_q
);
  logic [REG_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_data & WR_MASK;
    if (ack)
      ctl_d[B_GIE] = 1'b0;
    else if (ret && !wr_en)
      ctl_d[B_GIE] = 1'b1;
    // hardware set is applied last so it overrides a software clear
    ctl_d[N_SRC-1:0] = ctl_d[N_SRC-1:0] | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
  import irq_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ctl,
  input  logic             sleeping,
  output logic             irq_req,
  output logic             vec_req,
  output logic             wake_req
);
  logic pend;
  logic glob;

  assign pend = |(ctl[N_SRC-1:0] & ctl[B_PC_E +: N_SRC]);
  assign glob = ctl[B_GIE] & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      vec_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      irq_req  <= glob;
      vec_req  <= glob & ~sleeping;
      wake_req <= pend & sleeping;
    end
  end
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic             edge_rise,
  input  logic             tmr_wrap,
  input  logic [NIB_W-1:0] port_hi,
  input  logic             port_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             int_ack,
  input  logic             reti,
  input  logic             sleeping,
  output logic             irq_req,
  output logic             vec_req,
  output logic             wake_req
);
  logic             pin_hit;
  logic             nib_diff;
  logic [N_SRC-1:0] hw_set;
  logic [REG_W-1:0] ctl;

  pin_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .pin      (ext_pin),
    .rise_sel (edge_rise),
    .hit      (pin_hit)
  );

  nib_change_det #(.W(NIB_W), .SYNC_STAGES(SYNC_STAGES)) u_nib (
    .clk  (clk),
    .rst  (rst),
    .pins (port_hi),
    .snap (port_rd),
    .diff (nib_diff)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[B_PC_F]  = nib_diff;
    hw_set[B_PIN_F] = pin_hit;
    hw_set[B_TMR_F] = tmr_wrap;
  end

  irq_ctl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .hw_set  (hw_set),
    .wr_en   (reg_wr),
    .wr_data (wr_data),
    .ack     (int_ack),
    .ret     (reti),
    .ctl_q   (ctl)
  );

  irq_out_gen u_out (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .sleeping (sleeping),
    .irq_req  (irq_req),
    .vec_req  (vec_req),
    .wake_req (wake_req)
  );

  assign rd_data = ctl;
endmodule

// File: rtl/irq_flag_ctl_chk.sv
module irq_flag_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       tmr_wrap,
  input logic       reg_wr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       int_ack,
  input logic       sleeping,
  input logic       irq_req,
  input logic       vec_req,
  input logic       wake_req
);
  a_r4_tmr_sets: assert property (@(posedge clk) disable iff (rst)
    tmr_wrap |=> rd_data[2]);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (tmr_wrap && reg_wr && !wr_data[2]) |=> rd_data[2]);

  a_r6_pin_sticky: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && rd_data[1]) |=> rd_data[1]);

  a_r6_pc_sticky: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && rd_data[0]) |=> rd_data[0]);

  a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_data[6]);

  a_r8_gie_gate: assert property (@(posedge clk) disable iff (rst)
    !rd_data[7] |=> !irq_req);

  a_r9_awake_no_wake: assert property (@(posedge clk) disable iff (rst)
    !sleeping |=> !wake_req);

  a_r10_vec_awake: assert property (@(posedge clk) disable iff (rst)
    sleeping |=> !vec_req);

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !rd_data[7]);
endmodule

bind irq_flag_ctl irq_flag_ctl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tmr_wrap (tmr_wrap),
  .reg_wr   (reg_wr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .int_ack  (int_ack),
  .sleeping (sleeping),
  .irq_req  (irq_req),
  .vec_req  (vec_req),
  .wake_req (wake_req)
);

// File: tb/irq_flag_ctl_test.sv
module irq_flag_ctl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_pin = 1'b0;
  logic       edge_rise = 1'b1;
  logic       tmr_wrap = 1'b0;
  logic [3:0] port_hi = 4'h0;
  logic       port_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       int_ack = 1'b0;
  logic       reti = 1'b0;
  logic       sleeping = 1'b0;
  logic       irq_req, vec_req, wake_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_flag_ctl uut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .edge_rise(edge_rise),
    .tmr_wrap(tmr_wrap), .port_hi(port_hi), .port_rd(port_rd),
    .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data),
    .int_ack(int_ack), .reti(reti), .sleeping(sleeping),
    .irq_req(irq_req), .vec_req(vec_req), .wake_req(wake_req)
  );

  // behavioural reference: sample history of pins, register image, outputs
  logic [2:0] pin_hist;
  logic [3:0] nib_hist [2];
  logic [3:0] nib_ref;
  logic [7:0] m_reg;
  logic       m_irq, m_vec, m_wake;

  always @(posedge clk) begin
    logic [7:0] n;
    logic       pend, pin_ev, nib_ev;
    if (rst) begin
      pin_hist = '0; nib_hist[0] = '0; nib_hist[1] = '0; nib_ref = '0;
      m_reg = '0; m_irq = 0; m_vec = 0; m_wake = 0;
    end else begin
      pin_ev = (pin_hist[1] != pin_hist[2]) && (pin_hist[1] == edge_rise);
      nib_ev = (nib_hist[1] != nib_ref);
      pend = (m_reg[0] && m_reg[3]) || (m_reg[1] && m_reg[4]) || (m_reg[2] && m_reg[5]);
      m_irq  = m_reg[7] && pend;
      m_vec  = m_irq && !sleeping;
      m_wake = sleeping && pend;
      n = m_reg;
      if (reg_wr) n = {wr_data[7], 1'b0, wr_data[5:0]};
      if (int_ack) n[7] = 1'b0;
      else if (reti && !reg_wr) n[7] = 1'b1;
      if (nib_ev) n[0] = 1'b1;
      if (pin_ev) n[1] = 1'b1;
      if (tmr_wrap) n[2] = 1'b1;
      m_reg = n;
      if (port_rd) nib_ref = nib_hist[1];
      nib_hist[1] = nib_hist[0];
      nib_hist[0] = port_hi;
      pin_hist = {pin_hist[1:0], ext_pin};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R12 timing and all functions)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rd_data == m_reg, "R12 model register", rd_data, m_reg);
      chk(irq_req == m_irq, "R8 model irq_req", irq_req, m_irq);
      chk(vec_req == m_vec, "R10 model vec_req", vec_req, m_vec);
      chk(wake_req == m_wake, "R9 model wake_req", wake_req, m_wake);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; wr_data = d; tick(1); reg_wr = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk(rd_data == 8'h00, "R1 reset register", rd_data, 0);
    chk({irq_req, vec_req, wake_req} == 3'b000, "R1 reset outputs",
        {irq_req, vec_req, wake_req}, 0);

    // R12 latency and R2 rising edge
    edge_rise = 1'b1; ext_pin = 1'b1;
    tick(1); chk(rd_data[1] == 1'b0, "R12 pin first edge", rd_data[1], 0);
    tick(1); chk(rd_data[1] == 1'b0, "R12 pin second edge", rd_data[1], 0);
    tick(1); chk(rd_data[1] == 1'b1, "R2 rising edge sets", rd_data[1], 1);
    wr(8'h00);
    ext_pin = 1'b0; tick(5);
    chk(rd_data[1] == 1'b0, "R2 falling edge ignored", rd_data[1], 0);

    // R3 falling polarity
    edge_rise = 1'b0; ext_pin = 1'b1; tick(5);
    chk(rd_data[1] == 1'b0, "R3 rising edge ignored", rd_data[1], 0);
    ext_pin = 1'b0; tick(5);
    chk(rd_data[1] == 1'b1, "R3 falling edge sets", rd_data[1], 1);
    wr(8'h00);

    // R4 timer
    tmr_wrap = 1'b1; tick(1); tmr_wrap = 1'b0;
    chk(rd_data[2] == 1'b1, "R4 timer wrap sets", rd_data[2], 1);
    wr(8'h00);

    // R5 port change
    port_hi = 4'h5; tick(5);
    chk(rd_data[0] == 1'b1, "R5 port change sets", rd_data[0], 1);
    wr(8'h00); tick(1);
    chk(rd_data[0] == 1'b1, "R5 clear while mismatched re-sets", rd_data[0], 1);
    port_rd = 1'b1; tick(1); port_rd = 1'b0; tick(1);
    wr(8'h00); tick(4);
    chk(rd_data[0] == 1'b0, "R5 reference refreshed by read", rd_data[0], 0);

    // R6 write mask and sticky
    wr(8'h78);
    chk(rd_data == 8'h38, "R6 reserved bit reads 0", rd_data, 8'h38);
    tmr_wrap = 1'b1; tick(1); tmr_wrap = 1'b0; tick(5);
    chk(rd_data[2] == 1'b1, "R6 flag sticky", rd_data[2], 1);
    chk(irq_req == 1'b0, "R8 no irq without global enable", irq_req, 0);
    chk(wake_req == 1'b0, "R9 no wake while awake", wake_req, 0);
    sleeping = 1'b1; tick(2);
    chk(wake_req == 1'b1, "R9 wake without global enable", wake_req, 1);
    chk(vec_req == 1'b0, "R10 no vector without global enable", vec_req, 0);

    // R10 vector with global enable
    sleeping = 1'b0; wr(8'hBC); tick(1);
    chk(irq_req == 1'b1, "R8 irq with global enable", irq_req, 1);
    chk(vec_req == 1'b1, "R10 vector when awake", vec_req, 1);
    sleeping = 1'b1; tick(2);
    chk(vec_req == 1'b0, "R10 no vector while asleep", vec_req, 0);
    chk(wake_req == 1'b1, "R9 wake while asleep", wake_req, 1);
    sleeping = 1'b0;

    // R11 ack and return
    int_ack = 1'b1; tick(1); int_ack = 1'b0;
    chk(rd_data[7] == 1'b0, "R11 ack clears global enable", rd_data[7], 0);
    tick(1);
    chk(irq_req == 1'b0, "R11 irq drops after ack", irq_req, 0);
    reti = 1'b1; tick(1); reti = 1'b0;
    chk(rd_data[7] == 1'b1, "R11 return sets global enable", rd_data[7], 1);
    int_ack = 1'b1; reg_wr = 1'b1; wr_data = 8'hB8; tick(1);
    int_ack = 1'b0; reg_wr = 1'b0;
    chk(rd_data[7] == 1'b0, "R11 ack beats write", rd_data[7], 0);

    // R7 set beats clear
    wr(8'h38);
    reg_wr = 1'b1; wr_data = 8'h38; tmr_wrap = 1'b1; tick(1);
    reg_wr = 1'b0; tmr_wrap = 1'b0;
    chk(rd_data[2] == 1'b1, "R7 set wins over clear", rd_data[2], 1);

    // R8 disabled source
    wr(8'hA0);
    edge_rise = 1'b1; ext_pin = 1'b1; tick(5);
    chk(rd_data[1] == 1'b1, "R8 disabled pin flag still sets", rd_data[1], 1);
    chk(irq_req == 1'b0, "R8 disabled source no irq", irq_req, 0);

    tick(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule